// File: doc/BRIEF.md
# Processor Status Flag Register Unit

This unit holds the eight-bit status byte of a small accumulator CPU and works out how each flag changes. Each cycle it takes a one-hot operation vector, the accumulator and memory operands, a shift carry-in and a shift direction. For add and subtract it produces the result itself, in binary or, when the decimal flag is set, in packed BCD. It then writes the new flag values into the status register at the clock edge.

The live status byte drives the CPU's branch and interrupt logic. The unit also outputs the byte to be pushed on the stack and the arithmetic result. When a software break is pushed, the stacked image carries a break bit that the live register never holds. Fetch, decode, addressing and the stack memory are handled elsewhere. Result, push image and interrupt enable are combinational from the current inputs and register; the status register changes only on a rising clock edge.

Top module: `psr_unit`

## Requirements
- R1: On synchronous reset the status byte becomes 0x04: only the interrupt-mask flag I (bit 2) is 1. irq_en is therefore 0.
- R2: The status bits are C=0, Z=1, I=2, D=3, B=4, T=5, V=6, N=7. Bit 4 of status_q is 0 at all times.
- R3: Binary ADC (op bit 0, D=0) gives result = A+M+C. C becomes the carry out of bit 7. V is set when the signed sum falls outside -128..127. Z is set when the result is zero, and N takes result bit 7.
- R4: Binary SBC (op bit 1, D=0) gives result = A-M-(1-C). C=1 means no borrow. V, Z and N follow the same rules as in R3.
- R5: With D=1 and valid BCD operands, ADC and SBC give the two-digit BCD sum or difference, modulo 100. C is the decimal carry, or for SBC the no-borrow indication. Z, V and N keep their previous values.
- R6: Shift (op bit 2) with shift_left=1 gives result = {A[6:0],shift_cin} and C=A[7]. With shift_left=0 it gives result = {shift_cin,A[7:1]} and C=A[0]. Z and N follow the result, and V is unchanged.
- R7: Transfer (op bit 3) gives result = M and sets Z and N from it. C and V are unchanged.
- R8: Bit test (op bit 4) gives result = A&M, sets Z when A&M is zero, and copies M[6] into V and M[7] into N. C is unchanged.
- R9: Flag operation (op bit 5) writes flag_val into the status bit named by flag_sel when flag_sel is 0, 2, 3 or 5. flag_sel=6 clears V whatever flag_val is. Any other flag_sel value changes nothing.
- R10: During break (op bit 6), push_img equals status_q with bit 4 set. At every other time push_img equals status_q. After a break, I is 1.
- R11: Status pull (op bit 7) loads M into the register, except bit 4, which stays 0.
- R12: irq_en is the inverse of I.
- R13: If op_vec does not have exactly one bit set, the status byte does not change and result is 0.
- R14: Flags that an operation does not name keep their values; in particular C, D, I and T survive every operation that does not name them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vec | input | 8 | One-hot operation select |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand / pulled status |
| shift_cin | input | 1 | Bit shifted into the vacated position |
| shift_left | input | 1 | Shift direction, 1 = toward MSB |
| flag_sel | input | 3 | Status bit index for flag operations |
| flag_val | input | 1 | Value written by flag operations |
| status_q | output | 8 | Live status register |
| push_img | output | 8 | Byte to be pushed on the stack |
| result | output | 8 | Arithmetic / shift / transfer result |
| irq_en | output | 1 | Maskable interrupts accepted |

## Verification
The decimal adder is tried with every pair of BCD operands, both carry-in values and both operations. Before each such operation a status pull loads random Z, V and N bits, so the test can tell a correct digit correction apart from a missed correction or a wrongly propagated carry, and can confirm that Z, V and N are left alone in decimal mode. Random binary operands near the sign boundary separate signed overflow from unsigned carry. Random mixes of flag operations, shifts, transfers, bit tests, breaks, pulls and non-one-hot vectors show whether each operation touches only the flags it names. Directed cases cover a pull of 0xFF, which must leave bit 4 clear, a break push, and the flag selectors that must be ignored.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int DATA_W = 8;
    localparam int NDIG   = DATA_W / 4;
    localparam int MSB    = DATA_W - 1;
    localparam int NOPS   = 8;
    localparam int SEL_W  = $clog2(DATA_W);

    // operation vector bit positions
    localparam int OPB_ADC = 0;
    localparam int OPB_SBC = 1;
    localparam int OPB_SHF = 2;
    localparam int OPB_XFR = 3;
    localparam int OPB_BIT = 4;
    localparam int OPB_FLG = 5;
    localparam int OPB_BRK = 6;
    localparam int OPB_PLL = 7;

    // status bit positions
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_I = 2;
    localparam int FB_D = 3;
    localparam int FB_B = 4;
    localparam int FB_T = 5;
    localparam int FB_V = 6;
    localparam int FB_N = 7;

    localparam logic [DATA_W-1:0] STATUS_RST = DATA_W'(1) << FB_I;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              ovf;
    } alu_res_t;

    function automatic logic is_onehot(input logic [NOPS-1:0] v);
        return $countones(v) == 1;
    endfunction

    // One decimal digit: returns {carry_or_borrow, digit}
    function automatic logic [4:0] bcd_digit(input logic [3:0] a, input logic [3:0] m,
                                             input logic ci, input logic sub);
        logic signed [6:0] t;
        logic              co;
        if (!sub) begin
            t  = {3'b000, a} + {3'b000, m} + {6'b0, ci};
            co = (t > 7'sd9);
            if (co) t = t + 7'sd6;
        end else begin
            t  = {3'b000, a} - {3'b000, m} - {6'b0, ci};
            co = (t < 7'sd0);
            if (co) t = t - 7'sd6;
        end
        return {co, t[3:0]};
    endfunction

endpackage

// File: rtl/psr_alu.sv
module psr_alu
    import psr_pkg::*;
(
    input  logic [NOPS-1:0]   op_vec,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem,
    input  logic              c_in,
    input  logic              dec_mode,
    input  logic              shift_cin,
    input  logic              shift_left,
    output alu_res_t          res
);

    logic              sub;
    logic [DATA_W-1:0] mop;
    logic [DATA_W:0]   bsum;
    logic              bovf;

    assign sub  = op_vec[OPB_SBC];
    assign mop  = sub ? ~mem : mem;
    assign bsum = {1'b0, acc} + {1'b0, mop} + {{DATA_W{1'b0}}, c_in};
    assign bovf = (acc[MSB] == mop[MSB]) && (bsum[MSB] != acc[MSB]);

    // decimal digit chain: carry for add, borrow for subtract
    logic              dchain [NDIG+1];
    logic [DATA_W-1:0] dsum;
    logic              dcarry;

    assign dchain[0] = sub ? ~c_in : c_in;

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_dig
            logic [4:0] dg;
            assign dg            = bcd_digit(acc[4*g +: 4], mem[4*g +: 4], dchain[g], sub);
            assign dchain[g+1]   = dg[4];
            assign dsum[4*g +: 4] = dg[3:0];
        end
    endgenerate

    assign dcarry = sub ? ~dchain[NDIG] : dchain[NDIG];

    always_comb begin
        res = '0;
        if (is_onehot(op_vec)) begin
            if (op_vec[OPB_ADC] || op_vec[OPB_SBC]) begin
                if (dec_mode) begin
                    res.value = dsum;
                    res.carry = dcarry;
                end else begin
                    res.value = bsum[DATA_W-1:0];
                    res.carry = bsum[DATA_W];
                    res.ovf   = bovf;
                end
            end else if (op_vec[OPB_SHF]) begin
                if (shift_left) begin
                    res.value = {acc[DATA_W-2:0], shift_cin};
                    res.carry = acc[MSB];
                end else begin
                    res.value = {shift_cin, acc[DATA_W-1:1]};
                    res.carry = acc[0];
                end
            end else if (op_vec[OPB_XFR]) begin
                res.value = mem;
            end else if (op_vec[OPB_BIT]) begin
                res.value = acc & mem;
            end
        end
    end

endmodule

// File: rtl/psr_flags.sv
module psr_flags
    import psr_pkg::*;
(
    input  logic [NOPS-1:0]   op_vec,
    input  logic [DATA_W-1:0] cur,
    input  alu_res_t          res,
    input  logic [DATA_W-1:0] mem,
    input  logic [SEL_W-1:0]  flag_sel,
    input  logic              flag_val,
    output logic [DATA_W-1:0] nxt
);

    logic zero_res;
    assign zero_res = (res.value == '0);

    always_comb begin
        nxt = cur;
        if (is_onehot(op_vec)) begin
            if (op_vec[OPB_ADC] || op_vec[OPB_SBC]) begin
                nxt[FB_C] = res.carry;
                if (!cur[FB_D]) begin
                    nxt[FB_Z] = zero_res;
                    nxt[FB_V] = res.ovf;
                    nxt[FB_N] = res.value[MSB];
                end
            end else if (op_vec[OPB_SHF]) begin
                nxt[FB_C] = res.carry;
                nxt[FB_Z] = zero_res;
                nxt[FB_N] = res.value[MSB];
            end else if (op_vec[OPB_XFR]) begin
                nxt[FB_Z] = zero_res;
                nxt[FB_N] = res.value[MSB];
            end else if (op_vec[OPB_BIT]) begin
                nxt[FB_Z] = zero_res;
                nxt[FB_V] = mem[FB_V];
                nxt[FB_N] = mem[FB_N];
            end else if (op_vec[OPB_FLG]) begin
                case (int'(flag_sel))
                    FB_C, FB_I, FB_D, FB_T: nxt[flag_sel] = flag_val;
                    FB_V:                   nxt[FB_V]     = 1'b0;
                    default:                ;
                endcase
            end else if (op_vec[OPB_BRK]) begin
                nxt[FB_I] = 1'b1;
            end else if (op_vec[OPB_PLL]) begin
                nxt = mem;
            end
        end
        nxt[FB_B] = 1'b0;
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        op_vec,
    input  logic [7:0]        acc_in,
    input  logic [7:0]        mem_in,
    input  logic              shift_cin,
    input  logic              shift_left,
    input  logic [2:0]        flag_sel,
    input  logic              flag_val,
    output logic [7:0]        status_q,
    output logic [7:0]        push_img,
    output logic [7:0]        result,
    output logic              irq_en
);

    alu_res_t          alu_out;
    logic [DATA_W-1:0] status_nxt;

    psr_alu u_alu (
        .op_vec     (op_vec),
        .acc        (acc_in),
        .mem        (mem_in),
        .c_in       (status_q[FB_C]),
        .dec_mode   (status_q[FB_D]),
        .shift_cin  (shift_cin),
        .shift_left (shift_left),
        .res        (alu_out)
    );

    psr_flags u_flags (
        .op_vec   (op_vec),
        .cur      (status_q),
        .res      (alu_out),
        .mem      (mem_in),
        .flag_sel (flag_sel),
        .flag_val (flag_val),
        .nxt      (status_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) status_q <= STATUS_RST;
        else     status_q <= status_nxt;
    end

    always_comb begin
        push_img = status_q;
        if (is_onehot(op_vec) && op_vec[OPB_BRK]) push_img[FB_B] = 1'b1;
    end

    assign result = alu_out.value;
    assign irq_en = ~status_q[FB_I];

endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] op_vec,
    input logic [7:0] mem_in,
    input logic [7:0] status_q,
    input logic [7:0] push_img,
    input logic       irq_en
);

    AST_RESET_VALUE: assert property (@(posedge clk) rst |=> status_q == 8'h04); // R1
    AST_B_CLEAR: assert property (@(posedge clk) disable iff (rst) status_q[4] == 1'b0); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($countones(op_vec) != 1) |=> status_q == $past(status_q)); // R13
    AST_BIT_COPY: assert property (@(posedge clk) disable iff (rst)
        (op_vec == 8'h10) |=> status_q[7:6] == $past(mem_in[7:6])); // R8
    AST_BRK_MASK: assert property (@(posedge clk) disable iff (rst)
        (op_vec == 8'h40) |=> status_q[2]); // R10
    AST_BRK_IMAGE: assert property (@(posedge clk) disable iff (rst)
        (op_vec == 8'h40) |-> push_img == (status_q | 8'h10)); // R10
    AST_PULL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op_vec == 8'h80) |=> status_q == ($past(mem_in) & 8'hEF)); // R11
    AST_IRQ_EN: assert property (@(posedge clk) disable iff (rst)
        irq_en == !status_q[2]); // R12

endmodule

bind psr_unit psr_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_vec   (op_vec),
    .mem_in   (mem_in),
    .status_q (status_q),
    .push_img (push_img),
    .irq_en   (irq_en)
);

// File: tb/sim_psr_unit.sv
module sim_psr_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_vec = 8'h00, acc_in = 8'h00, mem_in = 8'h00;
    logic       shift_cin = 1'b0, shift_left = 1'b0, flag_val = 1'b0;
    logic [2:0] flag_sel = 3'd0;
    logic [7:0] status_q, push_img, result;
    logic       irq_en;

    int errors = 0;
    int checks = 0;
    logic [7:0] model_st;

    always #10 clk = ~clk;

    psr_unit u0 (
        .clk(clk), .rst(rst), .op_vec(op_vec), .acc_in(acc_in), .mem_in(mem_in),
        .shift_cin(shift_cin), .shift_left(shift_left), .flag_sel(flag_sel),
        .flag_val(flag_val), .status_q(status_q), .push_img(push_img),
        .result(result), .irq_en(irq_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic int bcd2int(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] int2bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic string req_of(input logic [7:0] op, input logic dec);
        case (op)
            8'h01: return dec ? "R5" : "R3";
            8'h02: return dec ? "R5" : "R4";
            8'h04: return "R6";
            8'h08: return "R7";
            8'h10: return "R8";
            8'h20: return "R9";
            8'h40: return "R10";
            8'h80: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic ref_step(input logic [7:0] st, input logic [7:0] op, input logic [7:0] a,
                            input logic [7:0] m, input logic cin, input logic left,
                            input logic [2:0] sel, input logic val,
                            output logic [7:0] res, output logic [7:0] nst);
        int v, sa, sm, s;
        nst = st; res = 8'h00;
        if ($countones(op) != 1) return;
        sa = $signed(a); sm = $signed(m);
        if (op == 8'h01 || op == 8'h02) begin
            if (st[3]) begin
                if (op == 8'h01) begin
                    v = bcd2int(a) + bcd2int(m) + int'(st[0]);
                    nst[0] = v > 99; res = int2bcd(v % 100);
                end else begin
                    v = bcd2int(a) - bcd2int(m) - (1 - int'(st[0]));
                    nst[0] = v >= 0; res = int2bcd((v + 100) % 100);
                end
            end else begin
                if (op == 8'h01) begin
                    v = int'(a) + int'(m) + int'(st[0]);
                    s = sa + sm + int'(st[0]);
                    nst[0] = v > 255;
                end else begin
                    v = int'(a) - int'(m) - (1 - int'(st[0]));
                    s = sa - sm - (1 - int'(st[0]));
                    nst[0] = v >= 0;
                end
                res = 8'(v);
                nst[6] = (s > 127) || (s < -128);
                nst[1] = res == 8'h00; nst[7] = res[7];
            end
        end else if (op == 8'h04) begin
            res = left ? {a[6:0], cin} : {cin, a[7:1]};
            nst[0] = left ? a[7] : a[0];
            nst[1] = res == 8'h00; nst[7] = res[7];
        end else if (op == 8'h08) begin
            res = m; nst[1] = res == 8'h00; nst[7] = res[7];
        end else if (op == 8'h10) begin
            res = a & m; nst[1] = res == 8'h00; nst[6] = m[6]; nst[7] = m[7];
        end else if (op == 8'h20) begin
            if (sel == 3'd0 || sel == 3'd2 || sel == 3'd3 || sel == 3'd5) nst[sel] = val;
            else if (sel == 3'd6) nst[6] = 1'b0;
        end else if (op == 8'h40) begin
            nst[2] = 1'b1;
        end else begin
            nst = m; nst[4] = 1'b0;
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] m,
                          input logic cin, input logic left, input logic [2:0] sel,
                          input logic val);
        logic [7:0] eres, enst, epush;
        string req;
        req = req_of(op, model_st[3]);
        ref_step(model_st, op, a, m, cin, left, sel, val, eres, enst);
        epush = model_st | ((op == 8'h40) ? 8'h10 : 8'h00);
        @(negedge clk);
        op_vec = op; acc_in = a; mem_in = m; shift_cin = cin; shift_left = left;
        flag_sel = sel; flag_val = val;
        #1;
        check({req, " result"}, result, eres);
        check("R10 push image", push_img, epush);
        @(posedge clk);
        #1;
        check({req, "/R14 status"}, status_q, enst);
        check("R2 B bit", {7'b0, status_q[4]}, 8'h00);
        check("R12 irq_en", {7'b0, irq_en}, {7'b0, ~enst[2]});
        model_st = enst;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset status", status_q, 8'h04);
        check("R1 reset irq_en", {7'b0, irq_en}, 8'h00);
        model_st = 8'h04;

        // directed corners
        run_op(8'h80, 8'h00, 8'hFF, 0, 0, 0, 0);   // R11 pull all ones, B stays 0
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd3, 0); // R9 clear D
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd6, 1); // R9 V cannot be set
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd1, 0); // R9 Z selector ignored
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd4, 1); // R9 B selector ignored
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd7, 0); // R9 N selector ignored
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd0, 0); // clear C
        run_op(8'h01, 8'h7F, 8'h01, 0, 0, 0, 0);   // R3 signed overflow
        run_op(8'h01, 8'hFF, 8'h01, 0, 0, 0, 0);   // R3 carry, zero
        run_op(8'h02, 8'h80, 8'h01, 0, 0, 0, 0);   // R4 signed overflow, no borrow
        run_op(8'h02, 8'h00, 8'h01, 0, 0, 0, 0);   // R4 borrow
        run_op(8'h03, 8'h12, 8'h34, 0, 0, 0, 0);   // R13 two bits set
        run_op(8'h00, 8'h12, 8'h00, 0, 0, 0, 0);   // R13 no bit set
        run_op(8'h20, 8'h00, 8'h00, 0, 0, 3'd2, 0); // R12 unmask
        run_op(8'h40, 8'h00, 8'h00, 0, 0, 0, 0);   // R10 break push
        run_op(8'h10, 8'hFF, 8'hC0, 0, 0, 0, 0);   // R8 bit test

        // R5 exhaustive decimal operand pairs
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++)
                for (int ai = 0; ai < 100; ai++)
                    for (int mi = 0; mi < 100; mi++) begin
                        logic [7:0] pv;
                        pv = (8'($urandom) & 8'hE6) | 8'h08 | 8'(c);
                        run_op(8'h80, 8'h00, pv, 0, 0, 0, 0);
                        run_op(s ? 8'h02 : 8'h01, int2bcd(ai), int2bcd(mi), 0, 0, 0, 0);
                    end

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int k;
            logic [7:0] op, a, m;
            k = int'($urandom_range(0, 9));
            if (k < 8) op = 8'h01 << k;
            else op = (k == 8) ? 8'h00 : (8'h01 << $urandom_range(0, 7)) | 8'h01 | 8'h02;
            a = 8'($urandom); m = 8'($urandom);
            if (model_st[3] && (op == 8'h01 || op == 8'h02)) begin
                a = int2bcd(int'($urandom_range(0, 99)));
                m = int2bcd(int'($urandom_range(0, 99)));
            end
            run_op(op, a, m, 1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule